// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio and emits a comparison pulse train for a downstream phase comparator. A two-modulus prescaler divides the input either by M or by M+1, where M is a power of two. A swallow counter and a main counter together decide how many prescaler cycles of each length make up one output period. The swallow value A picks how many prescaler cycles run long (M+1). The main value N is the total number of prescaler cycles in the period. One output period therefore lasts M·N + A input clocks.

Software-side logic writes A and N with a one-cycle load strobe.

- If the block is idle, a valid load starts the divider at once.
- If the block is running, a valid load is held as pending. It is applied at the next period boundary, so no period is ever cut short or stretched.
- A load with N below the minimum, or with N not greater than A, raises a configuration-error flag. That load is dropped, and the divider keeps its last valid ratio.

The controller is a three-state machine:

- `ST_IDLE`: no valid ratio yet; the prescaler is held in restart.
- `ST_SWALLOW`: the prescaler runs at M+1.
- `ST_MAIN`: the prescaler runs at M.

The named transitions are:

- `start`: `ST_IDLE` moves to `ST_SWALLOW` on a valid load with A≠0, or to `ST_MAIN` on a valid load with A=0.
- `swallow_done`: `ST_SWALLOW` moves to `ST_MAIN` at the prescaler terminal count that ends the A-th long cycle.
- `period_wrap`: `ST_MAIN` moves back to `ST_SWALLOW`, or stays in `ST_MAIN`, at the terminal count that ends the N-th cycle. The next value of A decides which.

Reset returns the machine to `ST_IDLE`.

Top module: `psw_divider`

## Requirements
- R1: After reset, `fp` and `config_error` are low, and `fp` stays low until the first valid load.
- R2: With valid stored values A and N, the distance between consecutive `fp` pulses is exactly M·N + A input clocks (M = 2^PRESC_LOG2).
- R3: Each period is made of A prescaler cycles of M+1 clocks, followed by N−A cycles of M clocks. The period ends only while the prescaler runs at M, and this holds even when A = N−1.
- R4: `fp` is high for exactly one input clock per period.
- R5: A valid load taken while idle makes the first `fp` appear exactly M·N + A clocks after the load edge (at the following sampling point).
- R6: A valid load taken mid-period leaves the current period at its old length. The new ratio governs the period that starts at the next boundary.
- R7: A load with N < N_MIN or N ≤ A sets `config_error` in the cycle after the load. Such a load does not change the period.
- R8: A valid load clears `config_error` in the cycle after the load.
- R9: A = 0 gives a period of exactly M·N clocks, with no long prescaler cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe that captures `swallow_in` and `main_in` |
| swallow_in | input | SWALLOW_W | Swallow value A |
| main_in | input | MAIN_W | Main count N |
| fp | output | 1 | One-clock comparison pulse, once per output period |
| config_error | output | 1 | High after a rejected load, cleared by a valid one |

## Verification
The bench builds the divider with PRESC_LOG2=3, SWALLOW_W=3, MAIN_W=6 and N_MIN=5. This gives a prescaler of 8/9, A from 0 to 7 and N from 5 to 63. With these values every period is at most a few hundred clocks. That brings the extreme ratios within a short run: the smallest N, the largest A and N, A=0, and A=N−1. Two rejected-load cases are exercised as well: N equal to A, and N just below the minimum. Because the periods are short, the bench can measure whole periods, both around mid-period reloads and straight after a start from idle.

// File: rtl/psw_pkg.sv
package psw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psw_state_t;
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
    parameter int PRESC_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic long_mode,
    output logic tc
);
    localparam int CW = PRESC_LOG2 + 1;
    localparam logic [CW-1:0] LEN_SHORT_M1 = CW'((1 << PRESC_LOG2) - 1);
    localparam logic [CW-1:0] LEN_LONG_M1  = CW'(1 << PRESC_LOG2);

    logic [CW-1:0] pc;
    logic          at_zero;

    assign at_zero = (pc == '0);
    assign tc      = at_zero && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (restart || at_zero) begin
            pc <= long_mode ? LEN_LONG_M1 : LEN_SHORT_M1;
        end else begin
            pc <= pc - 1'b1;
        end
    end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
#(
    parameter int SWALLOW_W = 6,
    parameter int MAIN_W    = 12,
    parameter int N_MIN     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SWALLOW_W-1:0] a_in,
    input  logic [MAIN_W-1:0]    n_in,
    input  logic                 tc,
    output logic                 restart,
    output logic                 next_long,
    output logic                 fp,
    output logic                 config_error,
    output psw_state_t           state_o
);
    psw_state_t state, state_d;

    logic [SWALLOW_W-1:0] a_cnt, a_act, a_pend, sel_a;
    logic [MAIN_W-1:0]    n_cnt, n_act, n_pend, sel_n;
    logic                 pend_vld;
    logic                 load_ok, start, period_end;

    assign load_ok    = (n_in >= MAIN_W'(N_MIN)) && (n_in > MAIN_W'(a_in));
    assign sel_a      = pend_vld ? a_pend : a_act;
    assign sel_n      = pend_vld ? n_pend : n_act;
    assign start      = (state == ST_IDLE) && load && load_ok;
    assign period_end = tc && (state != ST_IDLE) && (n_cnt == MAIN_W'(1));

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_d = (a_in != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (period_end)                             state_d = (sel_a != '0) ? ST_SWALLOW : ST_MAIN;
                else if (tc && a_cnt == SWALLOW_W'(1))      state_d = ST_MAIN;
            end
            ST_MAIN: begin
                if (period_end) state_d = (sel_a != '0) ? ST_SWALLOW : ST_MAIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign next_long = (state_d == ST_SWALLOW);
    assign restart   = (state == ST_IDLE);
    assign state_o   = state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt <= '0;
            n_cnt <= '0;
            a_act <= '0;
            n_act <= '0;
        end else if (start) begin
            a_cnt <= a_in;
            n_cnt <= n_in;
            a_act <= a_in;
            n_act <= n_in;
        end else if (period_end) begin
            a_cnt <= sel_a;
            n_cnt <= sel_n;
            a_act <= sel_a;
            n_act <= sel_n;
        end else if (tc && state != ST_IDLE) begin
            n_cnt <= n_cnt - 1'b1;
            if (state == ST_SWALLOW) a_cnt <= a_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_pend   <= '0;
            n_pend   <= '0;
            pend_vld <= 1'b0;
        end else if (load && load_ok && state != ST_IDLE) begin
            a_pend   <= a_in;
            n_pend   <= n_in;
            pend_vld <= 1'b1;
        end else if (period_end) begin
            pend_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp           <= 1'b0;
            config_error <= 1'b0;
        end else begin
            fp <= period_end;
            if (load) config_error <= !load_ok;
        end
    end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int PRESC_LOG2 = 6,
    parameter int SWALLOW_W  = 6,
    parameter int MAIN_W     = 12,
    parameter int N_MIN      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SWALLOW_W-1:0] swallow_in,
    input  logic [MAIN_W-1:0]    main_in,
    output logic                 fp,
    output logic                 config_error
);
    logic       tc_w, restart_w, long_w;
    psw_state_t state_w;

    psw_prescaler #(.PRESC_LOG2(PRESC_LOG2)) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart_w),
        .long_mode (long_w),
        .tc        (tc_w)
    );

    psw_ctrl #(
        .SWALLOW_W (SWALLOW_W),
        .MAIN_W    (MAIN_W),
        .N_MIN     (N_MIN)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .a_in         (swallow_in),
        .n_in         (main_in),
        .tc           (tc_w),
        .restart      (restart_w),
        .next_long    (long_w),
        .fp           (fp),
        .config_error (config_error),
        .state_o      (state_w)
    );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
    import psw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic       fp,
    input logic       config_error,
    input logic       tc,
    input logic       long_mode,
    input psw_state_t state
);
    // R4: the comparison pulse never lasts two clocks
    assert_fp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R3: a prescaler terminal count is never followed by another at once
    assert_tc_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    // R3: a long prescaler cycle is only requested while swallowing or leaving idle
    assert_long_in_swallow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (long_mode && state == ST_MAIN && !tc) |-> 1'b0);

    // R1: no pulse follows a cycle spent idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !fp);

    // R7: the error flag only rises after a load
    assert_cfg_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(config_error) |-> $past(load));

    // R8: the error flag only falls after a load
    assert_cfg_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(config_error) |-> $past(load));
endmodule

bind psw_divider psw_divider_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .fp           (fp),
    .config_error (config_error),
    .tc           (tc_w),
    .long_mode    (long_w),
    .state        (state_w)
);

// File: tb/psw_divider_tb_top.sv
module psw_divider_tb_top;
    localparam int PL2 = 3;
    localparam int SW  = 3;
    localparam int MW  = 6;
    localparam int M   = 1 << PL2;
    localparam int NV  = 8;

    localparam int VEC_A[NV] = '{0, 3, 4, 7, 0, 7, 1, 5};
    localparam int VEC_N[NV] = '{5, 5, 5, 63, 63, 8, 20, 6};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [SW-1:0] a_in = '0;
    logic [MW-1:0] n_in = '0;
    logic          fp, config_error;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    psw_divider #(.PRESC_LOG2(PL2), .SWALLOW_W(SW), .MAIN_W(MW), .N_MIN(5)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .swallow_in   (a_in),
        .main_in      (n_in),
        .fp           (fp),
        .config_error (config_error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedges until fp is seen high; optionally pulses load at count ld_at.
    task automatic run_to_fp(input int ld_at, input int a, input int n,
                             output int cnt, output int err_after);
        cnt = 0;
        err_after = -1;
        do begin
            @(negedge clk);
            cnt++;
            if (load) load = 1'b0;
            if (cnt == ld_at + 1) err_after = int'(config_error);
            if (cnt == ld_at) begin
                load = 1'b1;
                a_in = SW'(a);
                n_in = MW'(n);
            end
        end while (!fp && cnt < 3000);
    endtask

    task automatic check_width(input string req);
        @(negedge clk);
        check(req, int'(fp), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c, e, seen;
        repeat (3) @(negedge clk);
        check("R1 fp after reset", int'(fp), 0);
        check("R1 config_error after reset", int'(config_error), 0);
        rst_n = 1'b1;
        seen = 0;
        repeat (150) begin
            @(negedge clk);
            if (fp) seen++;
        end
        check("R1 no fp while idle", seen, 0);

        // R5: start from idle, A=2 N=10
        @(negedge clk);
        load = 1'b1; a_in = 3'd2; n_in = 6'd10;
        run_to_fp(-5, 0, 0, c, e);
        check("R5 first pulse latency", c, M*10 + 2 + 1);
        check_width("R4 pulse width");

        // vector table: load mid-period, old period kept, new applied next
        for (int i = 0; i < NV; i++) begin
            int old_t;
            old_t = (i == 0) ? M*10 + 2 : M*VEC_N[i-1] + VEC_A[i-1];
            run_to_fp(3, VEC_A[i], VEC_N[i], c, e);
            check("R6 current period unchanged by load", c, old_t - 1);
            check("R8 valid load leaves error low", e, 0);
            run_to_fp(-5, 0, 0, c, e);
            if (VEC_A[i] == 0) check("R9 A=0 period", c, M*VEC_N[i]);
            else if (VEC_A[i] == VEC_N[i]-1) check("R3 A=N-1 period", c, M*VEC_N[i] + VEC_A[i]);
            else check("R2 period", c, M*VEC_N[i] + VEC_A[i]);
            check_width("R4 pulse width");
        end
        // last period checked ended one negedge ago; resync on next fp
        run_to_fp(-5, 0, 0, c, e);
        check("R2 steady period", c, M*6 + 5 - 1);

        // R7: N below minimum
        run_to_fp(3, 0, 4, c, e);
        check("R7 error after N<min", e, 1);
        check("R7 period kept", c, M*6 + 5);
        run_to_fp(-5, 0, 0, c, e);
        check("R7 next period kept", c, M*6 + 5);

        // R7: N equal to A
        run_to_fp(3, 6, 6, c, e);
        check("R7 error after N=A", e, 1);
        run_to_fp(-5, 0, 0, c, e);
        check("R7 ratio kept after N=A", c, M*6 + 5);

        // R8: valid load clears error
        run_to_fp(3, 7, 8, c, e);
        check("R8 error cleared", e, 0);
        run_to_fp(-5, 0, 0, c, e);
        check("R2 period after recovery", c, M*8 + 7);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 fp in reset", int'(fp), 0);
        check("R1 error in reset", int'(config_error), 0);
        rst_n = 1'b1;
        seen = 0;
        repeat (200) begin
            @(negedge clk);
            if (fp) seen++;
        end
        check("R1 idle after reset", seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule